// File: doc/BRIEF.md
# ECC-Protected RAM with Register Test Access

This block wraps a RAM holding 64-bit words, each stored with 8 check bits. The check bits form an extended Hamming code: seven position parities plus one overall parity bit. Normal traffic uses a simple request port. When protection is on, a write computes and stores fresh check bits. A read decodes the stored word, corrects any single-bit fault, flags any double-bit fault, and records the outcome in a sticky error log that drives an interrupt line.

A second path is driven from a small register bus. It reads or writes raw stored data and raw check bits at a chosen address. Software can replace the data alone, the check bits alone, or both. This lets it plant a word that disagrees with its check bits, then prove through an ordinary read that the decoder corrects the word or flags it. A test access takes one memory cycle. During that cycle the normal port is stalled.

Register map (word offsets on `reg_addr`). 0x00 enable (bit 0). 0x01 access mode: bit 0 = write (1) or read (0), bit 1 = replace data, bit 2 = replace check bits. 0x02 launch: bit 0 = launch via A, bit 1 = launch via B, bit 8 = busy (read only). 0x03 test address. 0x04..0x07 test write data words 0..3. 0x08..0x0B test read data words 0..3. 0x0C/0x0D test write check words 0/1. 0x0E/0x0F test read check words 0/1. 0x10 error flags: bit 0 = single, bit 1 = double, write 1 to clear. 0x11 first failing address. Data word 0 is data bits 31:0 and word 1 is bits 63:32. The check byte is bits 7:0 of check word 0.

Top module: `ecc_tap_mem`

## Requirements
- R1: After reset, every register reads 0, and `mem_stall`, `mem_rvalid` and `irq` are 0.
- R2: With the enable bit (0x00 bit 0) clear, a normal write stores all-zero check bits. A normal read then returns the stored data unaltered and logs no error.
- R3: With the enable bit set, a normal read returns the last data written to that address and logs no error. `mem_rvalid` pulses and `mem_rdata` is valid two clock edges after the edge that accepts the request.
- R4: With the enable bit set, a normal read of a word with one flipped data bit or one flipped check bit returns the corrected data and sets the single flag (0x10 bit 0).
- R5: With the enable bit set, a normal read of a word with two flipped data bits returns the stored data uncorrected and sets the double flag (0x10 bit 1).
- R6: A test write with only the data-replace bit set stores the new data and keeps the old check bits. A test write with only the check-replace bit set stores the new check byte and keeps the old data.
- R7: A test read loads the raw stored data into 0x08/0x09 and the raw check byte into 0x0E. No correction is applied and no error is logged.
- R8: Writing launch bit 0, or bit 1 when `DUAL_PORT` is 1, starts one access. During that access the launch register reads busy (bit 8) plus the launch bit, and the bits clear after that one cycle. A launch written while busy is ignored.
- R9: `mem_stall` is high during the test access cycle. A normal request held through that cycle is not accepted then, and is served in the cycle after.
- R10: The error flags are sticky until 1 is written to them, each flag clears on its own, and 0x11 keeps the address of the first failing read since the flags were last all clear. `irq` is high while either flag is set.
- R11: Test data words 2 and 3, check word 1, and the unused upper bits of every register read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Normal access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | ADDR_W | Normal access word address |
| mem_wdata | input | 64 | Normal write data |
| mem_stall | output | 1 | Request not accepted this cycle |
| mem_rvalid | output | 1 | Read data valid pulse |
| mem_rdata | output | 64 | Read data, corrected when enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for last cycle's `reg_addr` |
| irq | output | 1 | High while an error flag is set |

## Verification
A table of data words is stored, then overwritten through the test path with no flip, one flip at the lowest, highest or middle bit, or two flips close together or far apart. Each case separates returned-corrected from returned-raw, and single from double logging. Directed cases flip one check bit, which must yield good data with a single flag. They also run with protection off, where a flip must come back as stored with nothing logged. Test reads must return the planted, uncorrected words. Mixed single and double faults exercise the first-address capture and the per-flag clears, and a normal read held across a test access shows the stall and the later service.

// File: rtl/ecc_tap_pkg.sv
package ecc_tap_pkg;
  localparam int DATA_W   = 64;
  localparam int CHK_W    = 8;
  localparam int HAM_W    = CHK_W - 1;
  localparam int CODE_TOP = DATA_W + HAM_W;

  localparam logic [4:0] RA_CTRL  = 5'h00;
  localparam logic [4:0] RA_MODE  = 5'h01;
  localparam logic [4:0] RA_LAUNCH= 5'h02;
  localparam logic [4:0] RA_TADDR = 5'h03;
  localparam logic [4:0] RA_WD0   = 5'h04;
  localparam logic [4:0] RA_WD1   = 5'h05;
  localparam logic [4:0] RA_RD0   = 5'h08;
  localparam logic [4:0] RA_RD1   = 5'h09;
  localparam logic [4:0] RA_WCHK  = 5'h0C;
  localparam logic [4:0] RA_RCHK  = 5'h0E;
  localparam logic [4:0] RA_EFLAG = 5'h10;
  localparam logic [4:0] RA_EADDR = 5'h11;

  // Position parities: data bits fill the non-power-of-two code positions.
  function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int di;
    h  = '0;
    di = 0;
    for (int p = 1; p <= CODE_TOP; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < HAM_W; i++)
          if (p[i]) h[i] = h[i] ^ d[di];
        di++;
      end
    end
    return h;
  endfunction

  function automatic logic [CHK_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham_bits(d);
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [DATA_W-1:0] ecc_fix(input logic [DATA_W-1:0] d,
                                                 input logic [HAM_W-1:0] syn);
    logic [DATA_W-1:0] r;
    int di;
    r  = d;
    di = 0;
    for (int p = 1; p <= CODE_TOP; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p[HAM_W-1:0] == syn) r[di] = ~r[di];
        di++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_tap_store.sv
module ecc_tap_store
  import ecc_tap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_data_en,
  input  logic              wr_chk_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHK_W-1:0]  wchk,
  output logic [DATA_W-1:0] rdata,
  output logic [CHK_W-1:0]  rchk
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_ram [DEPTH];
  logic [CHK_W-1:0]  chk_ram  [DEPTH];

  // Separate arrays give independent write enables for data and check bits.
  always_ff @(posedge clk) begin
    if (wr_data_en) data_ram[addr] <= wdata;
    if (wr_chk_en)  chk_ram[addr]  <= wchk;
    if (rd_en) begin
      rdata <= data_ram[addr];
      rchk  <= chk_ram[addr];
    end
  end
endmodule

// File: rtl/ecc_tap_dec.sv
module ecc_tap_dec
  import ecc_tap_pkg::*;
(
  input  logic [DATA_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  output logic [DATA_W-1:0] fixed_data,
  output logic              one_err,
  output logic              two_err
);
  logic [HAM_W-1:0] syn;
  logic             par;

  always_comb begin
    syn        = ham_bits(raw_data) ^ raw_chk[HAM_W-1:0];
    par        = (^raw_data) ^ (^raw_chk);
    one_err    = par;
    two_err    = !par && (syn != '0);
    fixed_data = par ? ecc_fix(raw_data, syn) : raw_data;
  end
endmodule

// File: rtl/ecc_tap_log.sv
module ecc_tap_log #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk_valid,
  input  logic              one_err,
  input  logic              two_err,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              clr_one,
  input  logic              clr_two,
  output logic              one_q,
  output logic              two_q,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              irq
);
  logic one_n, two_n, hit;

  always_comb begin
    hit   = chk_valid && (one_err || two_err);
    one_n = (one_q && !clr_one) || (chk_valid && one_err);
    two_n = (two_q && !clr_two) || (chk_valid && two_err);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      one_q     <= 1'b0;
      two_q     <= 1'b0;
      fail_addr <= '0;
      irq       <= 1'b0;
    end else begin
      one_q <= one_n;
      two_q <= two_n;
      irq   <= one_n || two_n;
      if (hit && !one_q && !two_q) fail_addr <= rd_addr;
    end
  end

  // R4 R5
  decode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |-> $onehot0({one_err, two_err}));
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (one_q || two_q));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (one_q || two_q) |=> $stable(fail_addr));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (one_q && !clr_one) |=> one_q);
endmodule

// File: rtl/ecc_tap_mem.sv
module ecc_tap_mem
  import ecc_tap_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter bit DUAL_PORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [63:0]       mem_wdata,
  output logic              mem_stall,
  output logic              mem_rvalid,
  output logic [63:0]       mem_rdata,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam logic [1:0] LAUNCH_MASK = DUAL_PORT ? 2'b11 : 2'b01;
  localparam int         APAD        = 32 - ADDR_W;

  logic              ecc_on, mode_wr, rep_data, rep_chk;
  logic [1:0]        launch_q;
  logic [ADDR_W-1:0] tap_addr;
  logic [DATA_W-1:0] tap_wdata, tap_rdata;
  logic [CHK_W-1:0]  tap_wchk, tap_rchk;
  logic              busy, norm_go;
  logic              rd_p1, tap_rd_p1;
  logic [ADDR_W-1:0] rd_addr_p1;

  logic [ADDR_W-1:0] st_addr;
  logic              st_rd, st_wd, st_wc;
  logic [DATA_W-1:0] st_wdata, st_rdata, dec_data;
  logic [CHK_W-1:0]  st_wchk, st_rchk, enc_chk;
  logic              dec_one, dec_two;
  logic              one_q, two_q, clr_one, clr_two;
  logic [ADDR_W-1:0] fail_addr;
  logic [31:0]       rd_mux;

  assign busy      = |launch_q;
  assign mem_stall = busy;
  assign norm_go   = mem_req && !busy;
  assign enc_chk   = ecc_on ? ecc_encode(mem_wdata) : '0;

  // Port sharing: the test access owns the RAM for its one cycle.
  always_comb begin
    if (busy) begin
      st_addr  = tap_addr;
      st_rd    = !mode_wr;
      st_wd    = mode_wr && rep_data;
      st_wc    = mode_wr && rep_chk;
      st_wdata = tap_wdata;
      st_wchk  = tap_wchk;
    end else begin
      st_addr  = mem_addr;
      st_rd    = norm_go && !mem_we;
      st_wd    = norm_go && mem_we;
      st_wc    = norm_go && mem_we;
      st_wdata = mem_wdata;
      st_wchk  = enc_chk;
    end
  end

  ecc_tap_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .addr(st_addr), .rd_en(st_rd), .wr_data_en(st_wd),
    .wr_chk_en(st_wc), .wdata(st_wdata), .wchk(st_wchk),
    .rdata(st_rdata), .rchk(st_rchk)
  );

  ecc_tap_dec u_dec (
    .raw_data(st_rdata), .raw_chk(st_rchk),
    .fixed_data(dec_data), .one_err(dec_one), .two_err(dec_two)
  );

  assign clr_one = reg_wr && (reg_addr == RA_EFLAG) && reg_wdata[0];
  assign clr_two = reg_wr && (reg_addr == RA_EFLAG) && reg_wdata[1];

  ecc_tap_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst(rst), .chk_valid(rd_p1 && ecc_on),
    .one_err(dec_one), .two_err(dec_two), .rd_addr(rd_addr_p1),
    .clr_one(clr_one), .clr_two(clr_two),
    .one_q(one_q), .two_q(two_q), .fail_addr(fail_addr), .irq(irq)
  );

  // Control registers and launch sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_on    <= 1'b0;
      mode_wr   <= 1'b0;
      rep_data  <= 1'b0;
      rep_chk   <= 1'b0;
      launch_q  <= '0;
      tap_addr  <= '0;
      tap_wdata <= '0;
      tap_wchk  <= '0;
    end else begin
      if (busy) launch_q <= '0;
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL:   ecc_on <= reg_wdata[0];
          RA_MODE:   {rep_chk, rep_data, mode_wr} <= reg_wdata[2:0];
          RA_LAUNCH: if (!busy) launch_q <= reg_wdata[1:0] & LAUNCH_MASK;
          RA_TADDR:  tap_addr <= reg_wdata[ADDR_W-1:0];
          RA_WD0:    tap_wdata[31:0]  <= reg_wdata;
          RA_WD1:    tap_wdata[63:32] <= reg_wdata;
          RA_WCHK:   tap_wchk <= reg_wdata[CHK_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  // Read pipeline: RAM register, then decode into output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1      <= 1'b0;
      tap_rd_p1  <= 1'b0;
      rd_addr_p1 <= '0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      tap_rdata  <= '0;
      tap_rchk   <= '0;
    end else begin
      rd_p1      <= norm_go && !mem_we;
      rd_addr_p1 <= mem_addr;
      tap_rd_p1  <= busy && !mode_wr;
      mem_rvalid <= rd_p1;
      if (rd_p1)     mem_rdata <= ecc_on ? dec_data : st_rdata;
      if (tap_rd_p1) begin
        tap_rdata <= st_rdata;
        tap_rchk  <= st_rchk;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL:   rd_mux = {31'd0, ecc_on};
      RA_MODE:   rd_mux = {29'd0, rep_chk, rep_data, mode_wr};
      RA_LAUNCH: rd_mux = {23'd0, busy, 6'd0, launch_q};
      RA_TADDR:  rd_mux = {{APAD{1'b0}}, tap_addr};
      RA_WD0:    rd_mux = tap_wdata[31:0];
      RA_WD1:    rd_mux = tap_wdata[63:32];
      RA_RD0:    rd_mux = tap_rdata[31:0];
      RA_RD1:    rd_mux = tap_rdata[63:32];
      RA_WCHK:   rd_mux = {24'd0, tap_wchk};
      RA_RCHK:   rd_mux = {24'd0, tap_rchk};
      RA_EFLAG:  rd_mux = {30'd0, two_q, one_q};
      RA_EADDR:  rd_mux = {{APAD{1'b0}}, fail_addr};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R8
  launch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    mem_stall |=> !rd_p1);
  // R3
  rvalid_order_chk: assert property (@(posedge clk) disable iff (rst)
    rd_p1 |=> mem_rvalid);
endmodule

// File: tb/ecc_tap_mem_tb.sv
module ecc_tap_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam logic [4:0] A_CTRL = 5'h00, A_MODE = 5'h01, A_LAUNCH = 5'h02,
    A_TADDR = 5'h03, A_WD0 = 5'h04, A_WD1 = 5'h05, A_WD2 = 5'h06, A_WD3 = 5'h07,
    A_RD0 = 5'h08, A_RD1 = 5'h09, A_WCHK = 5'h0C, A_WCHK1 = 5'h0D,
    A_RCHK = 5'h0E, A_EFLAG = 5'h10, A_EADDR = 5'h11;

  localparam int NV = 6;
  localparam logic [63:0] V_DATA [NV] = '{64'h0123_4567_89AB_CDEF,
    64'hFFFF_0000_AAAA_5555, 64'h0000_0000_0000_0001, 64'hDEAD_BEEF_CAFE_F00D,
    64'h8000_0000_0000_0000, 64'h1357_9BDF_2468_ACE0};
  localparam logic [63:0] V_FLIP [NV] = '{64'h0, 64'h1, 64'h8000_0000_0000_0000,
    64'h0000_0000_8000_0000, 64'h0000_0000_0000_0300, 64'h4000_0000_0000_0002};
  localparam int V_KIND [NV] = '{0, 1, 1, 1, 2, 2};

  logic clk = 0, rst = 1;
  logic mem_req = 0, mem_we = 0;
  logic [AW-1:0] mem_addr = '0;
  logic [63:0] mem_wdata = '0;
  logic mem_stall, mem_rvalid, irq;
  logic [63:0] mem_rdata;
  logic reg_wr = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_tap_mem #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_stall(mem_stall),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rw(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rr(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic nwrite(input logic [AW-1:0] a, input logic [63:0] d);
    mem_req = 1; mem_we = 1; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic nread(input logic [AW-1:0] a, output logic [63:0] d, output logic v);
    mem_req = 1; mem_we = 0; mem_addr = a;
    @(negedge clk);
    mem_req = 0;
    @(negedge clk);
    d = mem_rdata; v = mem_rvalid;
  endtask

  task automatic launch(input logic [31:0] bits);
    rw(A_LAUNCH, bits);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tap_write(input logic [AW-1:0] a, input logic [63:0] d,
                           input logic [7:0] c, input logic [2:0] mode);
    rw(A_TADDR, 32'(a)); rw(A_WD0, d[31:0]); rw(A_WD1, d[63:32]);
    rw(A_WCHK, {24'd0, c}); rw(A_MODE, {29'd0, mode});
    launch(1);
  endtask

  task automatic tap_read(input logic [AW-1:0] a, output logic [63:0] d, output logic [7:0] c);
    logic [31:0] lo, hi, ck;
    rw(A_TADDR, 32'(a)); rw(A_MODE, 0);
    launch(1);
    rr(A_RD0, lo); rr(A_RD1, hi); rr(A_RCHK, ck);
    d = {hi, lo}; c = ck[7:0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] d, exp;
    logic [7:0] c, c0;
    logic v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 stall", mem_stall, 0);
    check("R1 rvalid", mem_rvalid, 0);
    check("R1 irq", irq, 0);
    foreach (V_KIND[i]) begin
      logic [4:0] ra;
      ra = (i == 0) ? A_CTRL : (i == 1) ? A_MODE : (i == 2) ? A_LAUNCH :
           (i == 3) ? A_WD0 : (i == 4) ? A_EFLAG : A_EADDR;
      rr(ra, r);
      check("R1 register", r, 0);
    end

    // R11 unused words and bits
    rw(A_WD2, 32'hFFFF_FFFF); rr(A_WD2, r); check("R11 wdata2", r, 0);
    rw(A_WD3, 32'hFFFF_FFFF); rr(A_WD3, r); check("R11 wdata3", r, 0);
    rw(A_WCHK1, 32'hFFFF_FFFF); rr(A_WCHK1, r); check("R11 wchk1", r, 0);
    rw(A_WCHK, 32'hFFFF_FFFF); rr(A_WCHK, r); check("R11 wchk0 byte", r, 32'hFF);
    rw(A_CTRL, 32'hFFFF_FFFF); rr(A_CTRL, r); check("R11 ctrl bit", r, 1);

    // Table walk: R3 clean, R4 single data flip, R5 double data flip
    for (int i = 0; i < NV; i++) begin
      logic [AW-1:0] a;
      a = AW'(i + 1);
      nwrite(a, V_DATA[i]);
      tap_write(a, V_DATA[i] ^ V_FLIP[i], 8'h00, 3'b011);
      nread(a, d, v);
      exp = (V_KIND[i] == 2) ? (V_DATA[i] ^ V_FLIP[i]) : V_DATA[i];
      check(V_KIND[i] == 0 ? "R3 data" : V_KIND[i] == 1 ? "R4 data" : "R5 data", d, exp);
      check("R3 rvalid", v, 1);
      check("R10 irq", irq, V_KIND[i] != 0);
      rr(A_EFLAG, r);
      check(V_KIND[i] == 0 ? "R3 flags" : V_KIND[i] == 1 ? "R4 flags" : "R5 flags",
            r, V_KIND[i] == 0 ? 0 : V_KIND[i] == 1 ? 1 : 2);
      rw(A_EFLAG, 3);
    end

    // R7 raw test read of a planted single flip, no logging
    tap_read(2, d, c);
    check("R7 raw data", d, V_DATA[1] ^ V_FLIP[1]);
    rr(A_EFLAG, r); check("R7 no log", r, 0);

    // R6 data-only write keeps check bits; check-only write keeps data
    nwrite(30, 64'hA5A5_0F0F_1234_8765);
    tap_read(30, d, c0);
    tap_write(30, 64'hA5A5_0F0F_1234_8764, 8'h00, 3'b011);
    tap_read(30, d, c);
    check("R6 data replaced", d, 64'hA5A5_0F0F_1234_8764);
    check("R6 check kept", c, c0);
    nwrite(31, 64'h0F0F_F0F0_0000_FFFF);
    tap_read(31, d, c0);
    tap_write(31, 64'h0, c0 ^ 8'h04, 3'b101);
    tap_read(31, d, c);
    check("R6 data kept", d, 64'h0F0F_F0F0_0000_FFFF);
    check("R7 raw check", c, c0 ^ 8'h04);
    nread(31, d, v);
    check("R4 check-bit flip data", d, 64'h0F0F_F0F0_0000_FFFF);
    rr(A_EFLAG, r); check("R4 check-bit flip flag", r, 1);
    rw(A_EFLAG, 3);

    // R2 protection off
    rw(A_CTRL, 0);
    nwrite(40, 64'h1111_2222_3333_4444);
    tap_read(40, d, c);
    check("R2 zero check", c, 0);
    tap_write(40, 64'h1111_2222_3333_4447, 8'h00, 3'b011);
    nread(40, d, v);
    check("R2 raw data", d, 64'h1111_2222_3333_4447);
    rr(A_EFLAG, r); check("R2 no log", r, 0);
    check("R2 irq", irq, 0);
    rw(A_CTRL, 1);

    // R10 first address, per-flag clear
    nread(2, d, v);
    nread(5, d, v);
    rr(A_EFLAG, r); check("R10 both flags", r, 3);
    rr(A_EADDR, r); check("R10 first addr", r, 2);
    rw(A_EFLAG, 1);
    rr(A_EFLAG, r); check("R10 single cleared", r, 2);
    check("R10 irq held", irq, 1);
    rw(A_EFLAG, 2);
    rr(A_EFLAG, r); check("R10 all cleared", r, 0);
    check("R10 irq low", irq, 0);

    // R8 launch via B, busy readback, self-clear
    rw(A_TADDR, 1); rw(A_MODE, 0);
    rw(A_LAUNCH, 2);
    reg_addr = A_LAUNCH;
    @(negedge clk);
    check("R8 busy readback", reg_rdata, 32'h102);
    @(negedge clk);
    check("R8 self clear", reg_rdata, 0);
    rr(A_RD0, r); check("R8 port B access", r, V_DATA[0][31:0]);

    // R8 launch while busy ignored
    rw(A_LAUNCH, 1);
    check("R8 busy stall", mem_stall, 1);
    rw(A_LAUNCH, 1);
    check("R8 relaunch ignored", mem_stall, 0);

    // R9 stall and deferred service
    rw(A_LAUNCH, 1);
    check("R9 stall high", mem_stall, 1);
    mem_req = 1; mem_we = 0; mem_addr = 1;
    @(negedge clk);
    check("R9 stall released", mem_stall, 0);
    check("R9 not served", mem_rvalid, 0);
    @(negedge clk);
    mem_req = 0;
    check("R9 pending", mem_rvalid, 0);
    @(negedge clk);
    check("R9 served", mem_rvalid, 1);
    check("R9 data", mem_rdata, V_DATA[0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule